// File: doc/BRIEF.md
# Table-Driven Multi-Pattern Byte Matcher

The block walks a multi-pattern string automaton over a stream of characters. Each accepted character is joined to the current automaton state and to the active table region, and the result addresses an on-chip table. The table word returned for that address carries two things: the state to move to, and a vector with one bit per pattern. A set bit means that pattern ends at the character just consumed. The automaton is built offline. It is written into the table one word at a time through a plain write port, so a new pattern set needs new table contents and no change to the logic.

The table holds several regions, and each region is a complete automaton. A region-select input picks the region that the stream runs against, which limits recognition to that region's subset of patterns. Only a region that is not selected can be written. New tables can therefore be loaded while matching continues in the selected region.

Characters arrive on a valid/ready input, and match vectors leave on a valid/ready output. Each handshake on the output carries the result of exactly one accepted character, in the order the characters were accepted. When the output is held off, the result stays on the output and the input stops accepting. With the output ready and no control event pending, one character is accepted on every clock.

Top module: `ac_scan_engine`

## Requirements
- R1: After reset `out_valid` is 0, the automaton is in state 0, and `in_ready` is 1 when `out_ready` is 1.
- R2: A character accepted in state S, with active region G, reads the table word at address {G, S, char}, with the region in the top bits and the character in the low CHAR_W bits. The word's match field is presented on `out_match`, and its next-state field becomes the state for the following character. Bit k of `out_match` is 1 exactly when pattern k of the loaded set ends at that character.
- R3: While `out_ready` is 1, `load_commit` is 0 and `region_sel` is unchanged from the previous cycle, `in_ready` is 1, so one character is accepted per cycle.
- R4: The result of a character accepted at a clock edge is on the output, with `out_valid` at 1, from that edge onward.
- R5: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid` and `out_match` keep their values into the next cycle. No result is lost or duplicated.
- R6: A write with `wr_en` at 1 stores {`wr_next`, `wr_match`} at {`wr_region`, `wr_state`, `wr_char`} when `wr_region` differs from the active region. A write aimed at the active region is ignored and leaves the table unchanged.
- R7: A cycle with `load_commit` at 1 accepts no character, and the next character is looked up from state 0.
- R8: The active region follows `region_sel` with one cycle of delay. In the cycle where `region_sel` differs from the active region, `in_ready` is 0. The first character after the switch is looked up from state 0 in the new region.
- R9: Writes into an inactive region in the same cycles as characters are matched in the active region change neither the results nor the rate of acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input character is valid |
| in_ready | output | 1 | Engine accepts the input character |
| in_char | input | CHAR_W | Input character code |
| out_valid | output | 1 | Match vector is valid |
| out_ready | input | 1 | Consumer accepts the match vector |
| out_match | output | PAT_N | One bit per pattern, set when that pattern ends at the character |
| region_sel | input | REGION_W | Table region to match against |
| load_commit | input | 1 | Pulse that returns the automaton to state 0 |
| wr_en | input | 1 | Table write strobe |
| wr_region | input | REGION_W | Region of the word to write |
| wr_state | input | STATE_W | State field of the write address |
| wr_char | input | CHAR_W | Character field of the write address |
| wr_next | input | STATE_W | Next state to store |
| wr_match | input | PAT_N | Match vector to store |

## Verification
Two things can happen in the same cycle: a table write and a character lookup. The bench forces this by running a long character stream in one region while, in parallel, it rewrites every word of the other region with a new pattern set. Each match vector is compared with a direct suffix search over the characters seen so far, and the bench checks that the input never stalled during the stream. It then switches to the rewritten region and checks that the new patterns are detected. It also issues a write aimed at the active region and checks, through the match results that follow, that the write had no effect.

// File: rtl/ac_pkg.sv
package ac_pkg;
  localparam int unsigned AC_CHAR_W   = 8;
  localparam int unsigned AC_STATE_W  = 3;
  localparam int unsigned AC_REGION_W = 1;
  localparam int unsigned AC_PAT_N    = 4;
endpackage

// File: rtl/ac_table_ram.sv
module ac_table_ram #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read register holds its word while no lookup is issued.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ac_write_guard.sv
module ac_write_guard #(
  parameter int unsigned CHAR_W   = 8,
  parameter int unsigned STATE_W  = 3,
  parameter int unsigned REGION_W = 1,
  parameter int unsigned PAT_N    = 4,
  localparam int unsigned ADDR_W  = REGION_W + STATE_W + CHAR_W,
  localparam int unsigned DATA_W  = STATE_W + PAT_N
) (
  input  logic                wr_en,
  input  logic [REGION_W-1:0] wr_region,
  input  logic [STATE_W-1:0]  wr_state,
  input  logic [CHAR_W-1:0]   wr_char,
  input  logic [STATE_W-1:0]  wr_next,
  input  logic [PAT_N-1:0]    wr_match,
  input  logic [REGION_W-1:0] act_region,
  output logic                we,
  output logic [ADDR_W-1:0]   waddr,
  output logic [DATA_W-1:0]   wdata
);
  // The region being matched is never written.
  always_comb begin
    we    = wr_en && (wr_region != act_region);
    waddr = {wr_region, wr_state, wr_char};
    wdata = {wr_next, wr_match};
  end
endmodule

// File: rtl/ac_walker.sv
module ac_walker #(
  parameter int unsigned CHAR_W   = 8,
  parameter int unsigned STATE_W  = 3,
  parameter int unsigned REGION_W = 1,
  localparam int unsigned ADDR_W  = REGION_W + STATE_W + CHAR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [CHAR_W-1:0]   in_char,
  output logic                in_ready,
  input  logic                out_ready,
  output logic                out_valid,
  input  logic                load_commit,
  input  logic [REGION_W-1:0] region_sel,
  output logic [REGION_W-1:0] act_region,
  input  logic [STATE_W-1:0]  lookup_next,
  output logic                rd_en,
  output logic [ADDR_W-1:0]   rd_addr
);
  logic                fresh;
  logic [REGION_W-1:0] act_q;
  logic                accept;
  logic [STATE_W-1:0]  cur_state;

  // fresh: the read register holds the state reached by the last lookup.
  // Otherwise the automaton sits in state 0.
  always_comb begin
    in_ready   = (!out_valid || out_ready) && !load_commit && (region_sel == act_q);
    accept     = in_valid && in_ready;
    cur_state  = fresh ? lookup_next : '0;
    rd_en      = accept;
    rd_addr    = {act_q, cur_state, in_char};
    act_region = act_q;
  end

  always_ff @(posedge clk) begin
    act_q <= region_sel;
    if (rst) begin
      fresh     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (load_commit || (region_sel != act_q)) fresh <= 1'b0;
      else if (accept)                          fresh <= 1'b1;
      if (accept)         out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  assert_result_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_commit_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    load_commit |-> !in_ready);

  assert_switch_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (region_sel == $past(region_sel)));

  assert_full_rate_R3: assert property (@(posedge clk) disable iff (rst)
    (out_ready && !load_commit && (region_sel == $past(region_sel))) |-> in_ready);
endmodule

// File: rtl/ac_scan_engine.sv
module ac_scan_engine #(
  parameter int unsigned CHAR_W   = ac_pkg::AC_CHAR_W,
  parameter int unsigned STATE_W  = ac_pkg::AC_STATE_W,
  parameter int unsigned REGION_W = ac_pkg::AC_REGION_W,
  parameter int unsigned PAT_N    = ac_pkg::AC_PAT_N
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CHAR_W-1:0]   in_char,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [PAT_N-1:0]    out_match,
  input  logic [REGION_W-1:0] region_sel,
  input  logic                load_commit,
  input  logic                wr_en,
  input  logic [REGION_W-1:0] wr_region,
  input  logic [STATE_W-1:0]  wr_state,
  input  logic [CHAR_W-1:0]   wr_char,
  input  logic [STATE_W-1:0]  wr_next,
  input  logic [PAT_N-1:0]    wr_match
);
  localparam int unsigned ADDR_W = REGION_W + STATE_W + CHAR_W;
  localparam int unsigned DATA_W = STATE_W + PAT_N;

  logic                ram_we, ram_re;
  logic [ADDR_W-1:0]   ram_waddr, ram_raddr;
  logic [DATA_W-1:0]   ram_wdata, ram_rdata;
  logic [REGION_W-1:0] act_region;
  logic [STATE_W-1:0]  lookup_next;

  assign lookup_next = ram_rdata[DATA_W-1:PAT_N];
  assign out_match   = ram_rdata[PAT_N-1:0];

  ac_walker #(.CHAR_W(CHAR_W), .STATE_W(STATE_W), .REGION_W(REGION_W)) u_walk (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_char(in_char), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid),
    .load_commit(load_commit), .region_sel(region_sel), .act_region(act_region),
    .lookup_next(lookup_next), .rd_en(ram_re), .rd_addr(ram_raddr)
  );

  ac_write_guard #(.CHAR_W(CHAR_W), .STATE_W(STATE_W), .REGION_W(REGION_W), .PAT_N(PAT_N)) u_guard (
    .wr_en(wr_en), .wr_region(wr_region), .wr_state(wr_state), .wr_char(wr_char),
    .wr_next(wr_next), .wr_match(wr_match), .act_region(act_region),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata)
  );

  ac_table_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst(rst),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  assert_hold_output_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_match)));

  assert_stall_input_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_no_active_write_R6: assert property (@(posedge clk) disable iff (rst)
    (ram_we && ram_re) |-> (ram_waddr[ADDR_W-1 -: REGION_W] != ram_raddr[ADDR_W-1 -: REGION_W]));
endmodule

// File: tb/sim_ac_scan_engine.sv
`timescale 1ns/1ps
module sim_ac_scan_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_char = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [3:0] out_match;
  logic       region_sel = 1'b0;
  logic       load_commit = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_region = 1'b0;
  logic [2:0] wr_state = '0;
  logic [7:0] wr_char = '0;
  logic [2:0] wr_next = '0;
  logic [3:0] wr_match = '0;

  always #2.5 clk = ~clk;

  ac_scan_engine u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_char(in_char),
    .out_valid(out_valid), .out_ready(out_ready), .out_match(out_match),
    .region_sel(region_sel), .load_commit(load_commit),
    .wr_en(wr_en), .wr_region(wr_region), .wr_state(wr_state), .wr_char(wr_char),
    .wr_next(wr_next), .wr_match(wr_match)
  );

  int    tests = 0;
  int    fails = 0;
  string tag = "R2 R4";
  string psets [3][4];
  int    reg_set [2];
  string act_pats [4];
  string wp [4];
  string sts [8];
  int    nst;
  string hist = "";
  logic [3:0] expq [$];
  bit    bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] clfsr = 16'h1D2B;
  bit    prev_stall = 1'b0;
  logic [3:0] prev_val = '0;

  function automatic bit ends_with(string t, string p);
    if (p.len() == 0 || t.len() < p.len()) return 1'b0;
    return t.substr(t.len() - p.len(), t.len() - 1) == p;
  endfunction

  function automatic int find_state(string s);
    for (int i = 0; i < nst; i++) if (sts[i] == s) return i;
    return -1;
  endfunction

  // States are the distinct prefixes of the patterns; index 0 is the empty prefix.
  function automatic void build_states();
    nst = 1; sts[0] = "";
    for (int p = 0; p < 4; p++)
      for (int l = 1; l <= wp[p].len(); l++) begin
        string pre;
        pre = wp[p].substr(0, l - 1);
        if (find_state(pre) < 0 && nst < 8) begin sts[nst] = pre; nst++; end
      end
  endfunction

  function automatic void table_word(int s, int c, output int nx, output logic [3:0] m);
    string cs, t;
    nx = 0; m = '0;
    if (s >= nst || c < 8'h61 || c > 8'h64) return;
    cs = " "; cs.putc(0, byte'(c));
    t = {sts[s], cs};
    for (int k = 0; k < t.len(); k++) begin
      int idx;
      idx = find_state(t.substr(k, t.len() - 1));
      if (idx >= 0) begin nx = idx; break; end
    end
    for (int p = 0; p < 4; p++) m[p] = ends_with(t, wp[p]);
  endfunction

  task automatic check(bit ok, string req, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse_commit();
    @(negedge clk); load_commit = 1'b1;
    #1 check(in_ready == 1'b0, "R7 in_ready during commit", {7'd0, in_ready}, 8'd0);
    hist = "";
    @(negedge clk); load_commit = 1'b0;
  endtask

  task automatic load_region(int r, int set, bit commit);
    for (int p = 0; p < 4; p++) wp[p] = psets[set][p];
    build_states();
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 256; c++) begin
        int nx; logic [3:0] m;
        table_word(s, c, nx, m);
        @(negedge clk);
        wr_en = 1'b1; wr_region = r[0]; wr_state = 3'(s); wr_char = 8'(c);
        wr_next = 3'(nx); wr_match = m;
      end
    @(negedge clk); wr_en = 1'b0;
    reg_set[r] = set;
    if (commit) pulse_commit();
  endtask

  task automatic switch_region(int r);
    @(negedge clk); region_sel = r[0];
    #1 check(in_ready == 1'b0, "R8 in_ready on switch", {7'd0, in_ready}, 8'd0);
    for (int p = 0; p < 4; p++) act_pats[p] = psets[reg_set[r]][p];
    hist = "";
    @(negedge clk);
  endtask

  task automatic stream(string s, bit full_rate);
    int stalls = 0;
    for (int i = 0; i < s.len(); i++) begin
      logic [3:0] e;
      @(negedge clk); in_valid = 1'b1; in_char = s[i];
      while (!in_ready) begin @(negedge clk); stalls++; end
      hist = {hist, s.substr(i, i)};
      if (hist.len() > 8) hist = hist.substr(hist.len() - 8, hist.len() - 1);
      for (int p = 0; p < 4; p++) e[p] = ends_with(hist, act_pats[p]);
      expq.push_back(e);
    end
    @(negedge clk); in_valid = 1'b0;
    if (full_rate) check(stalls == 0, "R3 stall cycles", 8'(stalls), 8'd0);
  endtask

  function automatic string rand_text(int n);
    string r = "";
    string cs = " ";
    for (int i = 0; i < n; i++) begin
      clfsr = {clfsr[14:0], clfsr[15] ^ clfsr[13] ^ clfsr[12] ^ clfsr[10]};
      cs.putc(0, byte'(8'h61 + clfsr[1:0]));
      r = {r, cs};
    end
    return r;
  endfunction

  task automatic drain();
    int n = 0;
    while (expq.size() > 0 && n < 100) begin @(negedge clk); n++; end
    check(expq.size() == 0, "R4 results delivered", 8'(expq.size()), 8'd0);
  endtask

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= bp_mode ? lfsr[0] : 1'b1;
  end

  // Output monitor: one comparison per handshake, plus hold checks under back-pressure.
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        check(out_valid && out_match == prev_val, "R5 output held",
              {3'd0, out_valid, out_match}, {4'd1, prev_val});
      end
      if (out_valid && !out_ready)
        check(!in_ready, "R5 input stalled", {7'd0, in_ready}, 8'd0);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check(1'b0, "R4 unexpected result", {4'd0, out_match}, 8'd0);
        else begin
          logic [3:0] e;
          e = expq.pop_front();
          check(out_match == e, tag, {4'd0, out_match}, {4'd0, e});
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_val   = out_match;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    psets[0][0] = "ab";  psets[0][1] = "bc"; psets[0][2] = "abc"; psets[0][3] = "ca";
    psets[1][0] = "aa";  psets[1][1] = "ba"; psets[1][2] = "b";   psets[1][3] = "cc";
    psets[2][0] = "cab"; psets[2][1] = "a";  psets[2][2] = "bb";  psets[2][3] = "d";
    reg_set[0] = 0; reg_set[1] = 0;
    for (int p = 0; p < 4; p++) act_pats[p] = psets[0][p];

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", {7'd0, out_valid}, 8'd0);
    check(in_ready == 1'b1, "R1 in_ready after reset", {7'd0, in_ready}, 8'd1);

    // R6: load the inactive region 1, then match against it (R8 switch).
    load_region(1, 1, 1'b1);
    switch_region(1);
    tag = "R2 R4 set1";
    stream(rand_text(200), 1'b1);
    drain();

    load_region(0, 0, 1'b1);
    switch_region(0);
    tag = "R2 R4 set0";
    stream("abcabca", 1'b1);
    stream(rand_text(200), 1'b1);
    drain();

    // R5: random output back-pressure.
    tag = "R5 back-pressure";
    bp_mode = 1'b1;
    stream(rand_text(200), 1'b0);
    bp_mode = 1'b0;
    drain();

    // R7: commit returns the automaton to state 0, so "a" then "b" is not "ab".
    tag = "R7 commit";
    stream("a", 1'b1);
    pulse_commit();
    stream("bc", 1'b1);
    drain();

    // R6: a write aimed at the active region is ignored.
    @(negedge clk);
    wr_en = 1'b1; wr_region = 1'b0; wr_state = 3'd0; wr_char = 8'h61;
    wr_next = 3'd5; wr_match = 4'hF;
    @(negedge clk); wr_en = 1'b0;
    pulse_commit();
    tag = "R6 blocked write";
    stream("abab", 1'b1);
    drain();

    // R9: rewrite region 1 with a new set while region 0 keeps streaming.
    tag = "R9 concurrent load";
    fork
      stream(rand_text(600), 1'b1);
      load_region(1, 2, 1'b0);
    join
    drain();
    switch_region(1);
    tag = "R9 new set";
    stream("cabbda", 1'b1);
    stream(rand_text(200), 1'b1);
    drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule